// File: doc/BRIEF.md
# Vector Divide Operand Screening Unit

This block looks at a dividend vector and a divisor vector ahead of a software divide routine. Each vector is 128 bits wide and holds four IEEE-754 single-precision lanes. For every lane pair the block decides two things. The first is whether the quotient may fall outside the range the fast routine can handle: special operands, or exponents that are too large, too small or too far apart. The second is whether the operands need a guarded path, because of infinities, a zero divisor or a denormal divisor.

The per-lane decisions are ORed across the four lanes. The result is packed into a 4-bit condition value whose top bit is always set and whose bottom bit is always clear. A facility-enable input gates the result. When the facility is enabled, the condition value and its destination field index are presented with a write strobe one cycle after the request. When the facility is disabled, an unavailable-facility exception strobe is raised in place of the write. The block does no dividing and no reciprocal estimation. Reading the register file and writing the condition register are done outside it.

Top module: `vdiv_opscreen`

## Requirements
- R1: Lane i (i = 0..3) is bits [32*i+31 : 32*i] of each vector, and lane i of the dividend is paired only with lane i of the divisor. Within a lane, bit 31 is the sign, bits 30..23 are the exponent field and bits 22..0 are the fraction.
- R2: A lane raises its range flag when the dividend is a NaN or an infinity, or when the divisor is a zero, a NaN or an infinity. An all-ones exponent field with a nonzero fraction is a NaN. An all-ones exponent field with a zero fraction is an infinity. An all-zero exponent field with a zero fraction is a zero.
- R3: A lane raises its range flag when the divisor's unbiased exponent (field minus 127) is -126 or lower, or 125 or higher. That is the case when the divisor field is 1 or less, or 252 or more.
- R4: A lane raises its range flag when the dividend is not a zero and the dividend's unbiased exponent minus the divisor's is 127 or more, or -125 or less. A denormal counts as nonzero and has an unbiased exponent of -127. A zero dividend never raises the flag through this rule.
- R5: A lane raises its guard flag when the dividend is an infinity, or when the divisor is an infinity, a zero or a denormal (all-zero exponent field, nonzero fraction). A NaN dividend alone does not raise the guard flag.
- R6: The condition value is {1, OR of the guard flags, OR of the range flags, 0}, with the most significant bit first.
- R7: When the valid input is high and the enable input is 1 at a rising edge, then after that edge the condition value and the field index take their new values and the write strobe is high for exactly one cycle.
- R8: When the valid input is high and the enable input is 0, then after that edge the exception strobe is high for one cycle, the write strobe stays low and the condition value keeps its previous contents.
- R9: While the active-low synchronous reset is asserted, both strobes are driven to 0 and the condition value is cleared to 0000.
- R10: The sign bit of a lane has no effect on its classification or on its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Screening request strobe |
| dividend_vec | input | 128 | Four single-precision dividend lanes |
| divisor_vec | input | 128 | Four single-precision divisor lanes |
| field_idx_in | input | 3 | Destination condition field index |
| fac_enable | input | 1 | Facility enable; 0 turns a request into an exception |
| cond_nibble | output | 4 | Registered condition value |
| field_idx_out | output | 3 | Registered destination field index |
| cond_wr | output | 1 | Condition write strobe, one cycle |
| unavail_exc | output | 1 | Unavailable-facility exception strobe, one cycle |

## Verification
Every result of this block sits behind exactly one register. The condition value, the field index and both strobes are therefore due in the cycle that directly follows the edge at which the request was taken. The bench drives each request on a falling edge and holds it for one cycle. It then samples on the next falling edge, half a period after the capturing rising edge, so every check lands in that single result cycle. When the facility is disabled, the same sample point confirms that the condition value still holds the value from the last enabled request.

// File: rtl/dvs_pkg.sv
// Package: dvs_pkg
// Shared constants and the per-lane operand class type for the divide
// operand screening unit. Assumes IEEE-754 binary32 lanes.
package dvs_pkg;

    localparam int LANES   = 4;
    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int NIBBLE_W = 4;
    localparam int IDX_W   = 3;

    // Operand class of one lane; at most one bit is set.
    typedef struct packed {
        logic is_nan;
        logic is_inf;
        logic is_zero;
        logic is_den;
    } lane_class_t;

endpackage

// File: rtl/dvs_lane_classify.sv
// Module: dvs_lane_classify
// Classifies one floating-point lane (without its sign bit) as NaN,
// infinity, zero or denormal, and exposes the raw exponent field.
// Assumes the exponent sits directly above the fraction.
module dvs_lane_classify
    import dvs_pkg::*;
#(
    parameter int EXP_BITS  = EXP_W,
    parameter int FRAC_BITS = FRAC_W
) (
    input  logic [EXP_BITS+FRAC_BITS-1:0] mag,
    output lane_class_t                   cls,
    output logic [EXP_BITS-1:0]           exp_field
);

    logic [FRAC_BITS-1:0] frac;
    logic                 exp_ones;
    logic                 exp_zero;
    logic                 frac_zero;

    // Split the magnitude into its exponent and fraction fields.
    always_comb begin
        exp_field = mag[EXP_BITS+FRAC_BITS-1:FRAC_BITS];
        frac      = mag[FRAC_BITS-1:0];
        exp_ones  = &exp_field;
        exp_zero  = ~|exp_field;
        frac_zero = ~|frac;
    end

    // Derive the operand class from the field patterns.
    always_comb begin
        cls.is_nan  = exp_ones &  ~frac_zero;
        cls.is_inf  = exp_ones &   frac_zero;
        cls.is_zero = exp_zero &   frac_zero;
        cls.is_den  = exp_zero &  ~frac_zero;
    end

endmodule

// File: rtl/dvs_lane_rules.sv
// Module: dvs_lane_rules
// Applies the range and guard rules to one dividend/divisor lane pair.
// Assumes classified operands and raw exponent fields; the signed
// difference is two bits wider than the field so it cannot overflow.
module dvs_lane_rules
    import dvs_pkg::*;
#(
    parameter int EXP_BITS = EXP_W
) (
    input  lane_class_t         cls_a,
    input  lane_class_t         cls_b,
    input  logic [EXP_BITS-1:0] exp_a,
    input  logic [EXP_BITS-1:0] exp_b,
    output logic                range_hit,
    output logic                guard_hit
);

    localparam int DIFF_W = EXP_BITS + 2;
    localparam int BIAS   = (1 << (EXP_BITS - 1)) - 1;
    localparam logic signed [DIFF_W-1:0] BIAS_S  = DIFF_W'(BIAS);
    localparam logic signed [DIFF_W-1:0] B_LOW   = DIFF_W'(-(BIAS - 1));
    localparam logic signed [DIFF_W-1:0] B_HIGH  = DIFF_W'(BIAS - 2);
    localparam logic signed [DIFF_W-1:0] D_HIGH  = DIFF_W'(BIAS);
    localparam logic signed [DIFF_W-1:0] D_LOW   = DIFF_W'(-(BIAS - 2));

    logic signed [DIFF_W-1:0] ua;
    logic signed [DIFF_W-1:0] ub;
    logic signed [DIFF_W-1:0] delta;
    logic special_hit;
    logic divisor_exp_hit;
    logic delta_hit;

    // Unbias both exponents and form their signed difference.
    always_comb begin
        ua    = $signed({2'b00, exp_a}) - BIAS_S;
        ub    = $signed({2'b00, exp_b}) - BIAS_S;
        delta = ua - ub;
    end

    // Evaluate each range condition separately.
    always_comb begin
        special_hit     = cls_a.is_nan | cls_a.is_inf |
                          cls_b.is_zero | cls_b.is_nan | cls_b.is_inf;
        divisor_exp_hit = (ub <= B_LOW) | (ub >= B_HIGH);
        delta_hit       = ~cls_a.is_zero & ((delta >= D_HIGH) | (delta <= D_LOW));
    end

    // Combine into the lane's range and guard flags.
    always_comb begin
        range_hit = special_hit | divisor_exp_hit | delta_hit;
        guard_hit = cls_a.is_inf | cls_b.is_inf | cls_b.is_zero | cls_b.is_den;
    end

endmodule

// File: rtl/dvs_merge.sv
// Module: dvs_merge
// ORs the per-lane flags and packs them into the fixed condition
// pattern {1, guard, range, 0}. Purely combinational.
module dvs_merge
    import dvs_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [NLANES-1:0]   range_vec,
    input  logic [NLANES-1:0]   guard_vec,
    output logic [NIBBLE_W-1:0] nibble
);

    // Reduce across lanes and place the flags in the pattern.
    always_comb begin
        nibble = {1'b1, |guard_vec, |range_vec, 1'b0};
    end

endmodule

// File: rtl/vdiv_opscreen.sv
// Module: vdiv_opscreen
// Top of the divide operand screening unit. One lane classifier pair
// and one rule block per lane, a cross-lane merge, and one register
// stage for the condition value, field index and strobes.
// Assumes requests are single-cycle strobes; reset is synchronous, active low.
module vdiv_opscreen
    import dvs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*WORD_W-1:0] dividend_vec,
    input  logic [LANES*WORD_W-1:0] divisor_vec,
    input  logic [IDX_W-1:0]        field_idx_in,
    input  logic                    fac_enable,
    output logic [NIBBLE_W-1:0]     cond_nibble,
    output logic [IDX_W-1:0]        field_idx_out,
    output logic                    cond_wr,
    output logic                    unavail_exc
);

    localparam int MAG_W = EXP_W + FRAC_W;

    logic [LANES-1:0]    range_vec;
    logic [LANES-1:0]    guard_vec;
    logic [NIBBLE_W-1:0] nibble_d;
    logic                take_wr;
    logic                take_exc;

    // One screening slice per lane; sign bits are not routed in.
    for (genvar li = 0; li < LANES; li++) begin : g_lane
        lane_class_t       cls_a;
        lane_class_t       cls_b;
        logic [EXP_W-1:0]  exp_a;
        logic [EXP_W-1:0]  exp_b;

        dvs_lane_classify #(.EXP_BITS(EXP_W), .FRAC_BITS(FRAC_W)) u_cls_a (
            .mag       (dividend_vec[li*WORD_W +: MAG_W]),
            .cls       (cls_a),
            .exp_field (exp_a)
        );

        dvs_lane_classify #(.EXP_BITS(EXP_W), .FRAC_BITS(FRAC_W)) u_cls_b (
            .mag       (divisor_vec[li*WORD_W +: MAG_W]),
            .cls       (cls_b),
            .exp_field (exp_b)
        );

        dvs_lane_rules #(.EXP_BITS(EXP_W)) u_rules (
            .cls_a     (cls_a),
            .cls_b     (cls_b),
            .exp_a     (exp_a),
            .exp_b     (exp_b),
            .range_hit (range_vec[li]),
            .guard_hit (guard_vec[li])
        );
    end

    dvs_merge #(.NLANES(LANES)) u_merge (
        .range_vec (range_vec),
        .guard_vec (guard_vec),
        .nibble    (nibble_d)
    );

    // Decide which strobe a request produces.
    always_comb begin
        take_wr  = in_valid &  fac_enable;
        take_exc = in_valid & ~fac_enable;
    end

    // Register strobes; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_wr     <= 1'b0;
            unavail_exc <= 1'b0;
        end else begin
            cond_wr     <= take_wr;
            unavail_exc <= take_exc;
        end
    end

    // Register the condition value only on an enabled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_nibble <= '0;
        end else if (take_wr) begin
            cond_nibble <= nibble_d;
        end
    end

    // Register the destination index on every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_idx_out <= '0;
        end else if (in_valid) begin
            field_idx_out <= field_idx_in;
        end
    end

    // Assertions guarding the lane flags and the register stage.
    AST_GUARD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_vec & ~range_vec) == '0);  // R5
    AST_WR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fac_enable) |=> (cond_wr && !unavail_exc));  // R7
    AST_EXC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fac_enable) |=> (unavail_exc && !cond_wr));  // R8
    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!cond_wr && !unavail_exc));  // R7
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && fac_enable) |=> $stable(cond_nibble));  // R8
    AST_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        cond_wr |-> (cond_nibble[3] && !cond_nibble[0]));  // R6

endmodule

// File: tb/sim_vdiv_opscreen.sv
`timescale 1ns/1ps
module sim_vdiv_opscreen;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] dividend_vec = '0;
    logic [127:0] divisor_vec = '0;
    logic [2:0]   field_idx_in = '0;
    logic         fac_enable = 1'b0;
    logic [3:0]   cond_nibble;
    logic [2:0]   field_idx_out;
    logic         cond_wr;
    logic         unavail_exc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] last_nib = 4'b0000;

    always #2.5 clk = ~clk;

    vdiv_opscreen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .dividend_vec  (dividend_vec),
        .divisor_vec   (divisor_vec),
        .field_idx_in  (field_idx_in),
        .fac_enable    (fac_enable),
        .cond_nibble   (cond_nibble),
        .field_idx_out (field_idx_out),
        .cond_wr       (cond_wr),
        .unavail_exc   (unavail_exc)
    );

    function automatic logic [31:0] mk(input bit s, input int e, input int f);
        return {s, 8'(e), 23'(f)};
    endfunction

    // Reference: lane rules from the requirements (R2..R5).
    function automatic void ref_lane(input logic [31:0] a, input logic [31:0] b,
                                     output bit rng, output bit grd);
        int ea = int'(a[30:23]);
        int eb = int'(b[30:23]);
        bit fa0 = (a[22:0] == 0);
        bit fb0 = (b[22:0] == 0);
        bit a_nan = (ea == 255) && !fa0;
        bit a_inf = (ea == 255) && fa0;
        bit a_zero = (ea == 0) && fa0;
        bit b_nan = (eb == 255) && !fb0;
        bit b_inf = (eb == 255) && fb0;
        bit b_zero = (eb == 0) && fb0;
        bit b_den = (eb == 0) && !fb0;
        int ua = ea - 127;
        int ub = eb - 127;
        rng = a_nan || a_inf || b_zero || b_nan || b_inf ||
              (ub <= -126) || (ub >= 125) ||
              (!a_zero && ((ua - ub >= 127) || (ua - ub <= -125)));
        grd = a_inf || b_inf || b_zero || b_den;
    endfunction

    function automatic logic [3:0] ref_nib(input logic [127:0] a, input logic [127:0] b);
        bit r_any = 0;
        bit g_any = 0;
        for (int i = 0; i < 4; i++) begin
            bit r;
            bit g;
            ref_lane(a[32*i +: 32], b[32*i +: 32], r, g);
            r_any |= r;
            g_any |= g;
        end
        return {1'b1, g_any, r_any, 1'b0};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one request on a falling edge, sample one cycle later.
    task automatic apply(input logic [127:0] a, input logic [127:0] b,
                         input logic [2:0] idx, input bit en, input string tag);
        logic [3:0] exp_nib;
        @(negedge clk);
        dividend_vec = a;
        divisor_vec  = b;
        field_idx_in = idx;
        fac_enable   = en;
        in_valid     = 1'b1;
        exp_nib      = en ? ref_nib(a, b) : last_nib;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "cond_nibble", 32'(cond_nibble), 32'(exp_nib));
        check(tag, "cond_wr", 32'(cond_wr), 32'(en));
        check(tag, "unavail_exc", 32'(unavail_exc), 32'(!en));
        check(tag, "field_idx_out", 32'(field_idx_out), 32'(idx));
        last_nib = exp_nib;
    endtask

    // Same lane pair replicated into all four lanes.
    function automatic logic [127:0] rep(input logic [31:0] w);
        return {w, w, w, w};
    endfunction

    function automatic logic [31:0] rnd_word();
        int pick = int'($urandom_range(0, 9));
        int e;
        case (pick)
            0: e = 0;
            1: e = 255;
            2: e = int'($urandom_range(0, 3));
            3: e = int'($urandom_range(250, 254));
            default: e = int'($urandom_range(1, 254));
        endcase
        return mk(1'($urandom), e, ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 8388607)));
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "cond_wr", 32'(cond_wr), 0);
        check("R9", "unavail_exc", 32'(unavail_exc), 0);
        check("R9", "cond_nibble", 32'(cond_nibble), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "idle cond_wr", 32'(cond_wr), 0);

        // Plain operands: no flags (R6)
        apply(rep(mk(0, 130, 5)), rep(mk(0, 128, 7)), 3'd1, 1, "R6");
        check("R6", "clean value", 32'(cond_nibble), 32'(4'b1000));
        // R2 special operands
        apply(rep(mk(0, 255, 1)), rep(mk(0, 127, 0)), 3'd2, 1, "R2");
        apply(rep(mk(0, 127, 0)), rep(mk(0, 0, 0)), 3'd3, 1, "R2");
        apply(rep(mk(0, 127, 0)), rep(mk(0, 255, 9)), 3'd4, 1, "R2");
        // R5 guard cases
        apply(rep(mk(0, 255, 0)), rep(mk(0, 127, 0)), 3'd5, 1, "R5");
        check("R5", "inf dividend", 32'(cond_nibble), 32'(4'b1110));
        apply(rep(mk(0, 127, 0)), rep(mk(0, 0, 3)), 3'd6, 1, "R5");
        apply(rep(mk(0, 255, 4)), rep(mk(0, 127, 0)), 3'd7, 1, "R5");
        check("R5", "nan dividend no guard", 32'(cond_nibble), 32'(4'b1010));
        // R3 divisor exponent boundaries
        apply(rep(mk(0, 1, 0)), rep(mk(0, 1, 0)), 3'd0, 1, "R3");
        check("R3", "field 1", 32'(cond_nibble[1]), 1);
        apply(rep(mk(0, 2, 0)), rep(mk(0, 2, 0)), 3'd1, 1, "R3");
        check("R3", "field 2", 32'(cond_nibble[1]), 0);
        apply(rep(mk(0, 252, 0)), rep(mk(0, 252, 0)), 3'd2, 1, "R3");
        check("R3", "field 252", 32'(cond_nibble[1]), 1);
        apply(rep(mk(0, 251, 0)), rep(mk(0, 251, 0)), 3'd3, 1, "R3");
        check("R3", "field 251", 32'(cond_nibble[1]), 0);
        // R4 difference boundaries
        apply(rep(mk(0, 254, 0)), rep(mk(0, 127, 0)), 3'd4, 1, "R4");
        check("R4", "diff 127", 32'(cond_nibble[1]), 1);
        apply(rep(mk(0, 253, 0)), rep(mk(0, 127, 0)), 3'd5, 1, "R4");
        check("R4", "diff 126", 32'(cond_nibble[1]), 0);
        apply(rep(mk(0, 2, 0)), rep(mk(0, 127, 0)), 3'd6, 1, "R4");
        check("R4", "diff -125", 32'(cond_nibble[1]), 1);
        apply(rep(mk(0, 3, 0)), rep(mk(0, 127, 0)), 3'd7, 1, "R4");
        check("R4", "diff -124", 32'(cond_nibble[1]), 0);
        apply(rep(mk(0, 0, 0)), rep(mk(0, 250, 0)), 3'd0, 1, "R4");
        check("R4", "zero dividend exempt", 32'(cond_nibble), 32'(4'b1000));
        apply(rep(mk(0, 0, 1)), rep(mk(0, 127, 0)), 3'd1, 1, "R4");
        check("R4", "denormal dividend", 32'(cond_nibble[1]), 1);
        // R10 sign independence
        apply(rep(mk(1, 253, 0)), rep(mk(1, 127, 0)), 3'd2, 1, "R10");
        check("R10", "negative clean", 32'(cond_nibble), 32'(4'b1000));
        apply(rep(mk(1, 0, 0)), rep(mk(1, 0, 0)), 3'd3, 1, "R10");
        check("R10", "negative zero divisor", 32'(cond_nibble), 32'(4'b1110));
        // R1 single-lane triggers in each lane position
        for (int ln = 0; ln < 4; ln++) begin
            logic [127:0] b = rep(mk(0, 127, 0));
            b[32*ln +: 32] = mk(0, 0, 0);
            apply(rep(mk(0, 127, 0)), b, 3'(ln), 1, "R1");
            check("R1", "one lane", 32'(cond_nibble), 32'(4'b1110));
        end
        // R8 disabled facility keeps value
        apply(rep(mk(0, 255, 0)), rep(mk(0, 0, 0)), 3'd5, 0, "R8");
        check("R8", "value kept", 32'(cond_nibble), 32'(4'b1110));
        apply(rep(mk(0, 130, 0)), rep(mk(0, 128, 0)), 3'd6, 1, "R7");
        apply(rep(mk(0, 255, 0)), rep(mk(0, 0, 0)), 3'd2, 0, "R8");
        check("R8", "clean value kept", 32'(cond_nibble), 32'(4'b1000));
        @(negedge clk);
        check("R7", "strobe one cycle", 32'(cond_wr | unavail_exc), 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [127:0] a;
            logic [127:0] b;
            for (int ln = 0; ln < 4; ln++) begin
                a[32*ln +: 32] = rnd_word();
                b[32*ln +: 32] = ($urandom_range(0, 3) == 0) ? mk(0, 127, 0) : rnd_word();
            end
            apply(a, b, 3'($urandom), ($urandom_range(0, 7) != 0), "R6");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule